// File: doc/BRIEF.md
# Serial 4b/5b frame decoder with delimiter lock

This block takes a serial bit stream that has already been recovered at the line symbol rate. The most significant bit of each 5-bit code arrives first. While no frame is open, the block looks at the stream one bit at a time for the two-code start-of-frame pattern. When it finds the pattern, it fixes the symbol boundary there and opens a frame. From then on it classifies one 5-bit code every five clocks.

Inside a frame, data codes come out as 4-bit nibbles with a valid strobe. The two start codes are regenerated as preamble nibbles. Codes that carry no data are reported on a one-cycle error strobe. The frame closes cleanly on the two-code end-of-frame pair. It closes with an error when that pair is broken or when idle arrives too early. After any close, the block returns to its bit-by-bit search.

Top module: `rxd_frame_decoder`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `nib_vld`, `sym_err` and `in_frame` are all low.
- R2: While not in a frame, the block moves one bit per clock. It opens a frame when the last ten received bits are 1100010001, which is start code 18h followed by start code 11h. This works at any bit offset. `in_frame` is high after the edge that samples the final bit of the pattern.
- R3: After the edge that opens the frame, `nib_vld` is high with `nib` = 0101. On the edge one clock later, `nib_vld` is high with `nib` = 0101 again. This regenerates the two preamble nibbles.
- R4: In a frame, each data code gives its nibble on `nib`, with `nib_vld` high for one cycle. This happens after the edge that samples the code's last bit. Nibbles 0 to F come from codes 1Eh, 09h, 14h, 15h, 0Ah, 0Bh, 0Eh, 0Fh, 12h, 13h, 16h, 17h, 1Ah, 1Bh, 1Ch, 1Dh. At the other bit edges inside a slot, `nib_vld` is low.
- R5: In a frame, the following codes set `sym_err` for one cycle, give no valid nibble and leave the frame open: the fault code 04h, any code outside the data set and outside {1Fh, 18h, 11h, 0Dh, 07h}, and a stray 18h, 11h or 07h.
- R6: In a frame, end code 0Dh followed by 07h gives no nibble and no error, and `in_frame` drops after the slot of 07h. The block then searches bit by bit again.
- R7: In a frame, 0Dh followed by any code other than 07h sets `sym_err` for one cycle and closes the frame.
- R8: In a frame, idle code 1Fh arriving before an end pair sets `sym_err` for one cycle and closes the frame.
- R9: A start code 18h that is not directly followed by 11h opens no frame. `nib_vld`, `sym_err` and `in_frame` stay low.
- R10: `nib_vld` and `sym_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit | input | 1 | Received serial bit, MSB of each code first |
| nib | output | 4 | Decoded or regenerated nibble |
| nib_vld | output | 1 | One-cycle strobe: `nib` holds a new nibble |
| sym_err | output | 1 | One-cycle strobe: a non-data code was received, or the frame closed badly |
| in_frame | output | 1 | High while a frame is open |

## Verification
Two things can land on the same clock edge: the error report for a slot and the closing of the frame. This happens when an idle code arrives early, or when the end code is followed by something other than its partner. Each of these cases is provoked on its own frame. At that one edge the bench requires `sym_err` high and `in_frame` already low. At the next bit edge it requires the strobe gone and no reopening.

Every one of the 32 codes is also placed alone inside a freshly opened frame, with the lock point moved through all five bit offsets. This sweep separates three outcomes: codes that report an error and keep the frame open, codes that report an error and close it, and the clean end pair, which closes it silently.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] C_IDLE  = 5'h1F;
  localparam logic [SYM_W-1:0] C_SOF1  = 5'h18;
  localparam logic [SYM_W-1:0] C_SOF2  = 5'h11;
  localparam logic [SYM_W-1:0] C_EOF1  = 5'h0D;
  localparam logic [SYM_W-1:0] C_EOF2  = 5'h07;
  localparam logic [SYM_W-1:0] C_FAULT = 5'h04;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;

  typedef enum logic [2:0] {
    K_DATA, K_IDLE, K_SOF1, K_SOF2, K_EOF1, K_EOF2, K_FAULT, K_BAD
  } sym_kind_e;

  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_TAIL} fr_st_e;
endpackage

// File: rtl/rxd_sym_lut.sv
module rxd_sym_lut
  import rxd_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  output sym_kind_e        kind,
  output logic [NIB_W-1:0] dnib
);
  always_comb begin
    kind = K_DATA;
    dnib = '0;
    case (code)
      5'h1E: dnib = 4'h0;
      5'h09: dnib = 4'h1;
      5'h14: dnib = 4'h2;
      5'h15: dnib = 4'h3;
      5'h0A: dnib = 4'h4;
      5'h0B: dnib = 4'h5;
      5'h0E: dnib = 4'h6;
      5'h0F: dnib = 4'h7;
      5'h12: dnib = 4'h8;
      5'h13: dnib = 4'h9;
      5'h16: dnib = 4'hA;
      5'h17: dnib = 4'hB;
      5'h1A: dnib = 4'hC;
      5'h1B: dnib = 4'hD;
      5'h1C: dnib = 4'hE;
      5'h1D: dnib = 4'hF;
      C_IDLE:  kind = K_IDLE;
      C_SOF1:  kind = K_SOF1;
      C_SOF2:  kind = K_SOF2;
      C_EOF1:  kind = K_EOF1;
      C_EOF2:  kind = K_EOF2;
      C_FAULT: kind = K_FAULT;
      default: kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/rxd_shifter.sv
module rxd_shifter
  import rxd_pkg::*;
#(
  parameter int WIN_W = 2 * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  output logic [WIN_W-1:0] win_o
);
  logic [WIN_W-1:0] sh_q;

  assign win_o = {sh_q[WIN_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= win_o;
  end
endmodule

// File: rtl/rxd_slot_ctr.sv
module rxd_slot_ctr
  import rxd_pkg::*;
#(
  parameter int SLOT = SYM_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic last
);
  localparam int CNT_W = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(SLOT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign last = (cnt_q == LAST_V);

  always_comb begin
    if (clr || last) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/rxd_frame_decoder.sv
module rxd_frame_decoder
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  output logic [NIB_W-1:0] nib,
  output logic             nib_vld,
  output logic             sym_err,
  output logic             in_frame
);
  localparam int WIN_W = 2 * SYM_W;
  localparam logic [WIN_W-1:0] SOF_PAT = {C_SOF1, C_SOF2};

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [WIN_W-1:0] win;
  logic             slot_last, slot_clr;
  sym_kind_e        kind;
  logic [NIB_W-1:0] lut_nib;

  rxd_shifter #(.WIN_W(WIN_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .bit_i(rx_bit), .win_o(win)
  );

  rxd_slot_ctr #(.SLOT(SYM_W)) u_slot (
    .clk(clk), .rst_n(rst_i), .clr(slot_clr), .last(slot_last)
  );

  rxd_sym_lut u_lut (
    .code(win[SYM_W-1:0]), .kind(kind), .dnib(lut_nib)
  );

  fr_st_e           st_q, st_n;
  logic             pre_q, pre_n;
  logic [NIB_W-1:0] nib_q, nib_n;
  logic             nib_en;
  logic             vld_q, vld_n;
  logic             err_q, err_n;

  always_comb begin
    st_n     = st_q;
    pre_n    = 1'b0;
    nib_en   = 1'b0;
    nib_n    = nib_q;
    vld_n    = 1'b0;
    err_n    = 1'b0;
    slot_clr = 1'b0;
    case (st_q)
      ST_HUNT: begin
        if (win == SOF_PAT) begin
          st_n     = ST_BODY;
          slot_clr = 1'b1;
          pre_n    = 1'b1;
          nib_en   = 1'b1;
          nib_n    = PRE_NIB;
          vld_n    = 1'b1;
        end
      end
      ST_BODY: begin
        if (pre_q) begin
          nib_en = 1'b1;
          nib_n  = PRE_NIB;
          vld_n  = 1'b1;
        end
        if (slot_last) begin
          case (kind)
            K_DATA: begin
              nib_en = 1'b1;
              nib_n  = lut_nib;
              vld_n  = 1'b1;
            end
            K_EOF1: st_n = ST_TAIL;
            K_IDLE: begin
              err_n = 1'b1;
              st_n  = ST_HUNT;
            end
            default: err_n = 1'b1;
          endcase
        end
      end
      ST_TAIL: begin
        if (slot_last) begin
          st_n  = ST_HUNT;
          err_n = (kind != K_EOF2);
        end
      end
      default: st_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_HUNT;
      pre_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      pre_q <= pre_n;
      vld_q <= vld_n;
      err_q <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      nib_q <= '0;
    else if (nib_en) nib_q <= nib_n;
  end

  assign nib      = nib_q;
  assign nib_vld  = vld_q;
  assign sym_err  = err_q;
  assign in_frame = (st_q != ST_HUNT);
endmodule

// File: rtl/rxd_frame_decoder_chk.sv
module rxd_frame_decoder_chk
  import rxd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NIB_W-1:0] nib,
  input logic             nib_vld,
  input logic             sym_err,
  input logic             in_frame
);
  AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nib_vld && sym_err)); // R10
  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (nib_vld && nib == PRE_NIB)); // R3
  AST_PRE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |=> (nib_vld && nib == PRE_NIB && in_frame)); // R3
  AST_QUIET_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !nib_vld); // R9
  AST_ERR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> (in_frame || $fell(in_frame))); // R5
  AST_CLOSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> !nib_vld); // R6
endmodule

bind rxd_frame_decoder rxd_frame_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib(nib), .nib_vld(nib_vld),
  .sym_err(sym_err), .in_frame(in_frame)
);

// File: tb/rxd_frame_decoder_test.sv
module rxd_frame_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit;
  logic [3:0] nib;
  logic       nib_vld, sym_err, in_frame;
  int         checks = 0;
  int         errors = 0;
  logic       pre_next = 1'b0;

  always #4 clk = ~clk;

  rxd_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .nib(nib),
    .nib_vld(nib_vld), .sym_err(sym_err), .in_frame(in_frame)
  );

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'h1E;  1: return 5'h09;  2: return 5'h14;  3: return 5'h15;
      4: return 5'h0A;  5: return 5'h0B;  6: return 5'h0E;  7: return 5'h0F;
      8: return 5'h12;  9: return 5'h13; 10: return 5'h16; 11: return 5'h17;
      12: return 5'h1A; 13: return 5'h1B; 14: return 5'h1C; default: return 5'h1D;
    endcase
  endfunction

  function automatic int dec(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (enc(n) == c) return n;
    return -1;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_sym(input logic [4:0] c, input logic ev, input int en,
                          input logic ee, input logic ef, input string rq);
    for (int i = 4; i >= 0; i--) begin
      clock_bit(c[i]);
      if (i == 4 && pre_next) begin
        chk("R3", "second preamble vld", int'(nib_vld), 1);
        chk("R3", "second preamble nib", int'(nib), 5);
        pre_next = 1'b0;
      end else if (i != 0) begin
        chk("R4", "mid-slot vld", int'(nib_vld), 0);
        chk("R5", "mid-slot err", int'(sym_err), 0);
      end
    end
    chk(rq, "vld", int'(nib_vld), int'(ev));
    if (ev) chk(rq, "nib", int'(nib), en);
    chk(rq, "err", int'(sym_err), int'(ee));
    chk(rq, "in_frame", int'(in_frame), int'(ef));
    chk("R10", "vld and err together", int'(nib_vld & sym_err), 0);
  endtask

  task automatic open_frame(input int off);
    for (int k = 0; k < off; k++) clock_bit(1'b1);
    send_sym(5'h1F, 0, 0, 0, 0, "R2");
    send_sym(5'h18, 0, 0, 0, 0, "R2");
    send_sym(5'h11, 1, 5, 0, 1, "R2");
    pre_next = 1'b1;
  endtask

  task automatic close_ok();
    send_sym(5'h0D, 0, 0, 0, 1, "R6");
    send_sym(5'h07, 0, 0, 0, 0, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    rx_bit = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "vld in reset", int'(nib_vld), 0);
    chk("R1", "err in reset", int'(sym_err), 0);
    chk("R1", "frame in reset", int'(in_frame), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) clock_bit(1'b1);
    chk("R1", "vld after release", int'(nib_vld), 0);
    chk("R1", "frame after release", int'(in_frame), 0);

    // R4: every data code in one continuous frame
    open_frame(0);
    for (int n = 0; n < 16; n++) send_sym(enc(n), 1, n, 0, 1, "R4");
    close_ok();
    send_sym(5'h1F, 0, 0, 0, 0, "R6");

    // sweep of all 32 codes, one per frame, lock offset rotating
    for (int c = 0; c < 32; c++) begin
      int d;
      open_frame(c % 5);
      d = dec(5'(c));
      if (d >= 0) begin
        send_sym(5'(c), 1, d, 0, 1, "R4");
        close_ok();
      end else if (c == 'h0D) begin
        send_sym(5'(c), 0, 0, 0, 1, "R6");
        send_sym(5'h07, 0, 0, 0, 0, "R6");
      end else if (c == 'h1F) begin
        send_sym(5'(c), 0, 0, 1, 0, "R8");
      end else begin
        send_sym(5'(c), 0, 0, 1, 1, "R5");
        close_ok();
      end
      send_sym(5'h1F, 0, 0, 0, 0, "R6");
    end

    // R7: broken end pairs
    open_frame(2);
    send_sym(5'h0D, 0, 0, 0, 1, "R7");
    send_sym(5'h1E, 0, 0, 1, 0, "R7");
    send_sym(5'h1F, 0, 0, 0, 0, "R7");
    open_frame(1);
    send_sym(5'h0D, 0, 0, 0, 1, "R7");
    send_sym(5'h1F, 0, 0, 1, 0, "R7");
    send_sym(5'h1F, 0, 0, 0, 0, "R7");
    open_frame(3);
    send_sym(5'h0D, 0, 0, 0, 1, "R7");
    send_sym(5'h0D, 0, 0, 1, 0, "R7");
    send_sym(5'h1F, 0, 0, 0, 0, "R7");

    // R9: lone start code opens nothing
    send_sym(5'h18, 0, 0, 0, 0, "R9");
    send_sym(5'h1F, 0, 0, 0, 0, "R9");
    send_sym(5'h18, 0, 0, 0, 0, "R9");
    send_sym(5'h1E, 0, 0, 0, 0, "R9");
    send_sym(5'h09, 0, 0, 0, 0, "R9");
    send_sym(5'h1F, 0, 0, 0, 0, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule